// File: doc/BRIEF.md
# Boost converter stage emulator

This block emulates one bidirectional boost converter stage in fixed point, one time step per start strobe. At each step it latches the source-side voltage, the load-side current and the switch state, then advances the inductor current and the capacitor voltage by one forward-Euler step. It reports the new inductor current to the source model and the port voltage to the load model. The only inputs from the neighbouring models are that voltage and that current, so the source and load models can be swapped without touching this block.

A boost inverter uses two instances driven by complementary switch states. The AC output is the difference of their port voltages. One update runs through a sequencer that reuses a single signed multiplier four times. The done pulse arrives a fixed five cycles after start, well inside a 350 ns computation budget at 100 MHz. The step constants h/L, h/C, RL+Ron and Rc are parameters precomputed in the same Q format as the data.

Top module: `boost_emu_stage`

## Requirements
- R1: A synchronous active-high reset clears the inductor current, capacitor voltage and port voltage outputs to zero, and drives busy and done low.
- R2: A start seen high while idle at clock edge n raises busy after edge n for four cycles. Done is high for exactly one cycle after edge n+4, and busy is low at that point. This gives 50 ns per step at 100 MHz.
- R3: All data are signed two's complement with W bits, FRAC of them fractional (defaults 32 and 16). A product is the full product shifted right arithmetically by FRAC bits, then clamped to the W-bit range. When the switch input is 1, the new inductor current is iL + KHL·(vin − KRS·iL), computed as clamp(iL + mul(clamp(vin − mul(iL,KRS)), KHL)).
- R4: When the switch input is 0, with a = clamp(iL − io) and p = mul(a, KRC), the new inductor current is clamp(iL + mul(clamp(clamp(vin − mul(iL,KRS)) − clamp(vc + p)), KHL)).
- R5: The new capacitor voltage is clamp(vc + mul(a, KHC)). Here a = clamp(iL − io) when the switch input is 0, and a = clamp(−io) when it is 1.
- R6: The port voltage is clamp(vc + mul(a, KRC)). It uses the capacitor voltage from before the step and the same a as R5.
- R7: Every sum and product saturates at the most positive or most negative W-bit value instead of wrapping. Sustained drive therefore parks the states at those limits.
- R8: A start while busy is ignored, and input changes after the accepting edge do not affect the step in progress.
- R9: The three result outputs change only in the cycle where done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launches one emulation step when idle |
| sw_on | input | 1 | Switch state u for this step (1 = switch conducting) |
| vin_in | input | W | Source-side voltage, signed fixed point |
| io_in | input | W | Load-side current, signed fixed point |
| busy | output | 1 | A step is in progress |
| done | output | 1 | One-cycle pulse: results updated |
| il_out | output | W | Inductor current state, sent to the source model |
| vc_out | output | W | Capacitor voltage state |
| vo_out | output | W | Port voltage, sent to the load model |

## Verification
Every result is due in the cycle after the fifth rising edge counted from the one that accepted start. The bench drives inputs on falling edges and samples at the following falling edges. It expects busy high at the first sample and done low at the second through fourth samples. At the fifth sample it expects done high with all three results matching its own model, and at the sixth it expects done low again. During a step it also confirms that the results still hold the previous values. When it pokes start and scrambles the inputs mid-step, it checks that no second done appears afterwards.

// File: rtl/boost_emu_pkg.sv
`timescale 1ns/1ps
package boost_emu_pkg;
  // number of multiplier passes in one update
  localparam int STEPS = 4;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RS   = 3'd1,  // iL * (RL+Ron), and switch-gated current difference
    ST_RC   = 3'd2,  // Rc * difference
    ST_IL   = 3'd3,  // h/L * inductor voltage
    ST_VC   = 3'd4   // h/C * capacitor current, commit
  } step_e;
endpackage

// File: rtl/boost_emu_seq.sv
`timescale 1ns/1ps
module boost_emu_seq
  import boost_emu_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  output step_e step,
  output logic  capture,
  output logic  busy,
  output logic  done
);
  step_e step_q;

  assign step    = step_q;
  assign busy    = (step_q != ST_IDLE);
  assign capture = (step_q == ST_IDLE) && start;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= ST_IDLE;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (step_q)
        ST_IDLE: if (start) step_q <= ST_RS;
        ST_RS:   step_q <= ST_RC;
        ST_RC:   step_q <= ST_IL;
        ST_IL:   step_q <= ST_VC;
        ST_VC: begin
          step_q <= ST_IDLE;
          done   <= 1'b1;
        end
        default: step_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/boost_emu_mul.sv
`timescale 1ns/1ps
module boost_emu_mul #(
  parameter int W    = 32,
  parameter int FRAC = 16
) (
  input  logic signed [W-1:0] op_a,
  input  logic signed [W-1:0] op_b,
  output logic signed [W-1:0] prod
);
  localparam int PW = 2 * W;
  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic signed [PW-1:0] full;
  logic signed [PW-1:0] shifted;
  logic                 fits;

  always_comb begin
    full    = PW'(op_a) * PW'(op_b);
    shifted = full >>> FRAC;
    // result fits when all bits above the W-bit sign agree with it
    fits    = (shifted[PW-1:W-1] == {(PW-W+1){1'b0}}) ||
              (shifted[PW-1:W-1] == {(PW-W+1){1'b1}});
    if (fits)                prod = shifted[W-1:0];
    else if (shifted[PW-1])  prod = MINV;
    else                     prod = MAXV;
  end
endmodule

// File: rtl/boost_emu_core.sv
`timescale 1ns/1ps
module boost_emu_core
  import boost_emu_pkg::*;
#(
  parameter int W    = 32,
  parameter int K_HL = 697,
  parameter int K_HC = 3277,
  parameter int K_RS = 4653,
  parameter int K_RC = 3277
) (
  input  logic                clk,
  input  logic                rst,
  input  step_e               step,
  input  logic                capture,
  input  logic                sw_on,
  input  logic signed [W-1:0] vin_in,
  input  logic signed [W-1:0] io_in,
  input  logic signed [W-1:0] prod,
  output logic signed [W-1:0] mul_a,
  output logic signed [W-1:0] mul_b,
  output logic signed [W-1:0] il_q,
  output logic signed [W-1:0] vc_q,
  output logic signed [W-1:0] vo_q,
  output logic signed [W-1:0] lat_vin,
  output logic signed [W-1:0] lat_io,
  output logic                lat_gate
);
  localparam logic signed [W-1:0] ZERO = '0;
  localparam logic signed [W-1:0] C_HL = W'(K_HL);
  localparam logic signed [W-1:0] C_HC = W'(K_HC);
  localparam logic signed [W-1:0] C_RS = W'(K_RS);
  localparam logic signed [W-1:0] C_RC = W'(K_RC);
  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  function automatic logic signed [W-1:0] clamp_w(input logic signed [W:0] s);
    if (s[W] != s[W-1]) return s[W] ? MINV : MAXV;
    return s[W-1:0];
  endfunction

  function automatic logic signed [W-1:0] sat_add(input logic signed [W-1:0] x,
                                                  input logic signed [W-1:0] y);
    return clamp_w({x[W-1], x} + {y[W-1], y});
  endfunction

  function automatic logic signed [W-1:0] sat_sub(input logic signed [W-1:0] x,
                                                  input logic signed [W-1:0] y);
    return clamp_w({x[W-1], x} - {y[W-1], y});
  endfunction

  // per-step scratch registers
  logic signed [W-1:0] rs_term;   // (RL+Ron)*iL
  logic signed [W-1:0] diff_q;    // gated iL - io
  logic signed [W-1:0] rc_term;   // Rc*diff
  logic signed [W-1:0] il_next;

  logic signed [W-1:0] gated_v;   // (vc + Rc*diff) when switch open
  logic signed [W-1:0] ind_v;     // voltage across the inductor

  always_comb begin
    gated_v = lat_gate ? sat_add(vc_q, rc_term) : ZERO;
    ind_v   = sat_sub(sat_sub(lat_vin, rs_term), gated_v);
    unique case (step)
      ST_RS:   begin mul_a = il_q;   mul_b = C_RS; end
      ST_RC:   begin mul_a = diff_q; mul_b = C_RC; end
      ST_IL:   begin mul_a = ind_v;  mul_b = C_HL; end
      ST_VC:   begin mul_a = diff_q; mul_b = C_HC; end
      default: begin mul_a = ZERO;   mul_b = ZERO; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_vin  <= '0;
      lat_io   <= '0;
      lat_gate <= 1'b0;
      rs_term  <= '0;
      diff_q   <= '0;
      rc_term  <= '0;
      il_next  <= '0;
      il_q     <= '0;
      vc_q     <= '0;
      vo_q     <= '0;
    end else begin
      if (capture) begin
        lat_vin  <= vin_in;
        lat_io   <= io_in;
        lat_gate <= ~sw_on;
      end
      unique case (step)
        ST_RS: begin
          rs_term <= prod;
          diff_q  <= lat_gate ? sat_sub(il_q, lat_io) : sat_sub(ZERO, lat_io);
        end
        ST_RC: rc_term <= prod;
        ST_IL: il_next <= sat_add(il_q, prod);
        ST_VC: begin
          il_q <= il_next;
          vc_q <= sat_add(vc_q, prod);
          vo_q <= sat_add(vc_q, rc_term);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/boost_emu_stage.sv
`timescale 1ns/1ps
module boost_emu_stage
  import boost_emu_pkg::*;
#(
  parameter int W    = 32,
  parameter int FRAC = 16,
  parameter int K_HL = 697,   // h/L  = 500ns / 47uH
  parameter int K_HC = 3277,  // h/C  = 500ns / 10uF
  parameter int K_RS = 4653,  // RL + Ron = 71 mOhm
  parameter int K_RC = 3277   // Rc   = 50 mOhm
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                sw_on,
  input  logic signed [W-1:0] vin_in,
  input  logic signed [W-1:0] io_in,
  output logic                busy,
  output logic                done,
  output logic signed [W-1:0] il_out,
  output logic signed [W-1:0] vc_out,
  output logic signed [W-1:0] vo_out
);
  step_e               step;
  logic                capture;
  logic signed [W-1:0] mul_a, mul_b, prod;
  logic signed [W-1:0] lat_vin, lat_io;
  logic                lat_gate;

  boost_emu_seq seq_i (
    .clk(clk), .rst(rst), .start(start),
    .step(step), .capture(capture), .busy(busy), .done(done)
  );

  boost_emu_mul #(.W(W), .FRAC(FRAC)) mul_i (
    .op_a(mul_a), .op_b(mul_b), .prod(prod)
  );

  boost_emu_core #(
    .W(W), .K_HL(K_HL), .K_HC(K_HC), .K_RS(K_RS), .K_RC(K_RC)
  ) core_i (
    .clk(clk), .rst(rst), .step(step), .capture(capture),
    .sw_on(sw_on), .vin_in(vin_in), .io_in(io_in), .prod(prod),
    .mul_a(mul_a), .mul_b(mul_b),
    .il_q(il_out), .vc_q(vc_out), .vo_q(vo_out),
    .lat_vin(lat_vin), .lat_io(lat_io), .lat_gate(lat_gate)
  );
endmodule

// File: rtl/boost_emu_stage_chk.sv
`timescale 1ns/1ps
module boost_emu_stage_chk #(
  parameter int W     = 32,
  parameter int STEPS = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                busy,
  input logic                done,
  input logic                capture,
  input logic signed [W-1:0] il_out,
  input logic signed [W-1:0] vc_out,
  input logic signed [W-1:0] vo_out,
  input logic signed [W-1:0] lat_vin,
  input logic signed [W-1:0] lat_io,
  input logic                lat_gate
);
  localparam int CW = $clog2(STEPS + 1) + 1;
  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst)       busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_ends_busy_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_cnt < CW'(STEPS)));

  assert_capture_idle_R8: assert property (@(posedge clk) disable iff (rst)
    capture |-> !busy);

  assert_inputs_held_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(lat_vin) && $stable(lat_io) && $stable(lat_gate)));

  assert_out_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(il_out) && $stable(vc_out) && $stable(vo_out)));
endmodule

bind boost_emu_stage boost_emu_stage_chk #(.W(W), .STEPS(boost_emu_pkg::STEPS)) chk_i (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .capture(capture),
  .il_out(il_out), .vc_out(vc_out), .vo_out(vo_out),
  .lat_vin(lat_vin), .lat_io(lat_io), .lat_gate(lat_gate)
);

// File: tb/boost_emu_stage_tb_top.sv
`timescale 1ns/1ps
module boost_emu_stage_tb_top;
  localparam int     W    = 32;
  localparam int     FRAC = 16;
  localparam longint KHL  = 697;
  localparam longint KHC  = 3277;
  localparam longint KRS  = 4653;
  localparam longint KRC  = 3277;
  localparam longint TOP  = (longint'(1) <<< (W - 1)) - 1;
  localparam longint BOT  = -(longint'(1) <<< (W - 1));

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, sw_on = 1'b0;
  logic signed [W-1:0] vin_in = '0, io_in = '0;
  logic busy, done;
  logic signed [W-1:0] il_out, vc_out, vo_out;

  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;
  longint m_il = 0, m_vc = 0, m_vo = 0;

  always #5 clk = ~clk;

  boost_emu_stage dut_i (
    .clk(clk), .rst(rst), .start(start), .sw_on(sw_on),
    .vin_in(vin_in), .io_in(io_in), .busy(busy), .done(done),
    .il_out(il_out), .vc_out(vc_out), .vo_out(vo_out)
  );

  function automatic longint lim(input longint x);
    if (x > TOP) return TOP;
    if (x < BOT) return BOT;
    return x;
  endfunction

  function automatic longint fmul(input longint x, input longint y);
    return lim((x * y) >>> FRAC);
  endfunction

  // bench's own restatement of one Euler step (R3..R6)
  task automatic model_step(input longint vin, input longint io, input bit u);
    longint a, p, vl, open_v;
    a      = u ? lim(-io) : lim(m_il - io);
    p      = fmul(a, KRC);
    open_v = u ? 0 : lim(m_vc + p);
    vl     = lim(lim(vin - fmul(m_il, KRS)) - open_v);
    m_vo   = lim(m_vc + p);
    m_il   = lim(m_il + fmul(vl, KHL));
    m_vc   = lim(m_vc + fmul(a, KHC));
  endtask

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after done fell
  task automatic run_step(input longint vin, input longint io, input bit u, input bit poke);
    longint p_il, p_vc, p_vo;
    p_il = m_il; p_vc = m_vc; p_vo = m_vo;
    vin_in = W'(vin); io_in = W'(io); sw_on = u; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy after start", busy, 1);
    model_step(vin, io, u);
    for (int k = 2; k <= 4; k++) begin
      @(negedge clk);
      if (poke && k == 2) begin
        start = 1'b1; vin_in = ~vin_in; io_in = 32'sd12345; sw_on = ~u;
      end else begin
        start = 1'b0;
      end
      chk("R2 done not early", done, 0);
      chk("R9 il held mid-step", il_out, p_il);
      chk("R9 vc held mid-step", vc_out, p_vc);
      chk("R9 vo held mid-step", vo_out, p_vo);
    end
    @(negedge clk);
    start = 1'b0;
    chk("R2 done at fifth sample", done, 1);
    chk("R2 busy low with done", busy, 0);
    chk(u ? "R3 inductor current, switch on" : "R4 inductor current, switch off", il_out, m_il);
    chk("R5 capacitor voltage", vc_out, m_vc);
    chk("R6 port voltage", vo_out, m_vo);
    @(negedge clk);
    chk("R2 done single cycle", done, 0);
    if (poke) begin
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        chk("R8 no step from start while busy", done | busy, 0);
        chk("R8 il unchanged", il_out, m_il);
      end
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_il = 0; m_vc = 0; m_vo = 0;
    chk("R1 il zero", il_out, 0);
    chk("R1 vc zero", vc_out, 0);
    chk("R1 vo zero", vo_out, 0);
    chk("R1 busy/done low", busy | done, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    do_reset();

    // directed: one step each switch state from rest
    run_step(longint'(24) <<< FRAC, longint'(2) <<< FRAC, 1'b1, 1'b0);
    run_step(longint'(24) <<< FRAC, longint'(2) <<< FRAC, 1'b0, 1'b0);
    // R8: start pulsed and inputs scrambled during a step
    run_step(longint'(30) <<< FRAC, -(longint'(3) <<< FRAC), 1'b0, 1'b1);

    // constrained random operating points
    for (int n = 0; n < 200; n++) begin
      longint rv, ri;
      rv = longint'($urandom_range(100 << FRAC, 0)) - (longint'(50) <<< FRAC);
      ri = longint'($urandom_range(20 << FRAC, 0)) - (longint'(10) <<< FRAC);
      run_step(rv, ri, 1'($urandom_range(1, 0)), 1'b0);
    end

    // R1: reset from a nonzero state
    do_reset();

    // R7: drive both states into the positive limit
    for (int n = 0; n < 150; n++) run_step(TOP, BOT, 1'b1, 1'b0);
    chk("R7 il saturated high", il_out, TOP);
    chk("R7 vc saturated high", vc_out, TOP);
    // R7: then into the negative limit
    for (int n = 0; n < 260; n++) run_step(BOT, TOP, 1'b1, 1'b0);
    chk("R7 il saturated low", il_out, BOT);
    chk("R7 vc saturated low", vc_out, BOT);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule